// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache with Overlapped Translation

This block is the lookup and refill engine of a small data cache that sits behind an address translator. The low, untranslated part of a virtual address selects a set and a word, so both ways' tags and data are read while the translator is still converting the high part. The translated physical tag then arrives at the port and is compared with the two stored tags. The matching way supplies the requested word, or takes the write.

A miss stalls the requester while the engine refills the line over a 32-bit memory port. If the chosen victim is dirty, it is first written back. Writes that miss allocate the line and then merge into it. The requester presents a request together with its translation and holds both steady until `resp_valid`. After a refill completes, the held request is looked up again and then hits. With default parameters the cache has 256 sets of 16-byte lines. The set index and word select therefore fit inside a 4 KiB page offset, and the physical tag is 18 bits.

Top module: `vipt_dcache`

## Requirements
- R1: Out of reset every line is invalid, `resp_valid` and `mem_req` are low, and the first access to any set misses and refills.
- R2: An access hits only when `xlat_hit` is high, `xlat_fault` is low, and a valid way of the selected set holds a tag equal to `xlat_ptag`. The same set index with a different physical tag misses.
- R3: A hit is answered in the cycle it is presented, with no memory traffic. `req_vidx[1:0]` selects the word of the line and `req_vidx[9:2]` selects the set. A read returns that word on `resp_rdata`.
- R4: A write hit changes only the bytes whose `req_be` bit is set: bit b covers `req_wdata[8b+7:8b]`. The write marks the line dirty.
- R5: A write miss first fetches the whole line and then applies the byte merge. The other words of the line keep their memory values.
- R6: When the victim line is dirty, four write beats carrying its old physical address precede the four fill read beats. A clean victim causes no write beats.
- R7: The victim is an invalid way, way 0 first. If both ways are valid, the victim is the least recently used way. Recency is updated on every hit and every fill.
- R8: When `xlat_fault` is high, the access ends in the same cycle with `resp_valid` and `resp_fault` set. It causes no memory traffic and changes neither data, tags nor recency.
- R9: While `xlat_hit` and `xlat_fault` are both low, the access stalls: no response and no memory traffic.
- R10: Every line transfer is four beats at ascending word addresses, starting at the block-aligned address {tag, set, word, 2'b00}. Each beat holds its address and direction until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request, held until resp_valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_vidx | input | 10 | Untranslated page-offset word address: set in [9:2], word in [1:0] |
| req_be | input | 4 | Byte enables for a store |
| req_wdata | input | 32 | Store data |
| xlat_hit | input | 1 | Translation of the current request is available |
| xlat_fault | input | 1 | Translation reports a fault; the access is aborted |
| xlat_ptag | input | 18 | Physical tag from translation |
| resp_valid | output | 1 | Access completes this cycle |
| resp_fault | output | 1 | Completion is an abort on a fault |
| resp_rdata | output | 32 | Load data, valid with resp_valid on a load |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | Beat is a writeback |
| mem_addr | output | 30 | Physical byte address of the beat |
| mem_wdata | output | 32 | Writeback data |
| mem_ack | input | 1 | Memory accepts or returns the current beat |
| mem_rdata | input | 32 | Fill data, valid with mem_ack |

## Verification
The bench forces a tag alias: two physical tags on one set index. A design that compared virtual bits, or ignored the stored tag, would return the other page's data without any refill. It drives a recency sequence in which a hit must protect a line from the next eviction. It also evicts a dirty line and reads it back. A wrong recency bit would evict the just-used line, and a skipped writeback would bring stale memory back. Faulting writes, stalls of several cycles and stalled memory acknowledges are mixed into a seeded random stream. This catches designs that commit state on an aborted access, answer before translation, or advance a beat without its acknowledge.

// File: rtl/vipt_pkg.sv
// Shared definitions for the two-way data cache.
// Assumes exactly two ways; recency is kept as a single bit per set.
package vipt_pkg;
    localparam int unsigned NWAYS = 2;

    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_WBACK = 2'd1,
        CS_FILL  = 2'd2
    } cs_t;
endpackage

// File: rtl/vipt_tag_store.sv
// Tag, valid, dirty and recency storage.
// Read is asynchronous at lk_set; tags are unreset, valid/dirty/recency reset.
// Assumes fill and touch never occur in the same cycle.
module vipt_tag_store
    import vipt_pkg::*;
#(
    parameter int unsigned SETS  = 256,
    parameter int unsigned TAG_W = 18,
    localparam int unsigned IDX_W = $clog2(SETS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [IDX_W-1:0]            lk_set,
    output logic [NWAYS-1:0][TAG_W-1:0] lk_tag,
    output logic [NWAYS-1:0]            lk_valid,
    output logic [NWAYS-1:0]            lk_dirty,
    output logic                        lk_lru,
    input  logic                        touch_en,
    input  logic                        touch_way,
    input  logic                        mark_en,
    input  logic                        mark_way,
    input  logic                        fill_en,
    input  logic [IDX_W-1:0]            fill_set,
    input  logic                        fill_way,
    input  logic [TAG_W-1:0]            fill_tag
);
    logic [SETS-1:0] lru_q;

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        logic [TAG_W-1:0] tag_mem [SETS];
        logic [SETS-1:0]  valid_q;
        logic [SETS-1:0]  dirty_q;
        logic             is_fill;
        logic             is_mark;

        assign is_fill = fill_en && (fill_way == 1'(w));
        assign is_mark = mark_en && (mark_way == 1'(w));

        // Store the new physical tag when a fill of this way completes.
        always_ff @(posedge clk) begin
            if (is_fill) tag_mem[fill_set] <= fill_tag;
        end

        // Valid: cleared by reset, set by a completed fill.
        always_ff @(posedge clk) begin
            if (!rst_n)       valid_q <= '0;
            else if (is_fill) valid_q[fill_set] <= 1'b1;
        end

        // Dirty: cleared by a fill, set by a write hit.
        always_ff @(posedge clk) begin
            if (!rst_n)       dirty_q <= '0;
            else if (is_fill) dirty_q[fill_set] <= 1'b0;
            else if (is_mark) dirty_q[lk_set]   <= 1'b1;
        end

        assign lk_tag[w]   = tag_mem[lk_set];
        assign lk_valid[w] = valid_q[lk_set];
        assign lk_dirty[w] = dirty_q[lk_set];
    end

    // Recency: the bit names the way to evict next; the used way becomes recent.
    always_ff @(posedge clk) begin
        if (!rst_n)        lru_q <= '0;
        else if (fill_en)  lru_q[fill_set] <= ~fill_way;
        else if (touch_en) lru_q[lk_set]   <= ~touch_way;
    end

    assign lk_lru = lru_q[lk_set];
endmodule

// File: rtl/vipt_data_store.sv
// Line data for both ways, one word per entry.
// Asynchronous read of both ways at the lookup address, plus one read at
// the eviction address; one byte-enabled write per cycle.
module vipt_data_store
    import vipt_pkg::*;
#(
    parameter int unsigned SETS   = 256,
    parameter int unsigned WORDS  = 4,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned IDX_W = $clog2(SETS),
    localparam int unsigned OFF_W = $clog2(WORDS),
    localparam int unsigned BE_W  = DATA_W / 8
) (
    input  logic                         clk,
    input  logic [IDX_W-1:0]             lk_set,
    input  logic [OFF_W-1:0]             lk_word,
    output logic [NWAYS-1:0][DATA_W-1:0] lk_data,
    input  logic                         ev_way,
    input  logic [IDX_W-1:0]             ev_set,
    input  logic [OFF_W-1:0]             ev_word,
    output logic [DATA_W-1:0]            ev_data,
    input  logic                         wr_en,
    input  logic                         wr_way,
    input  logic [IDX_W-1:0]             wr_set,
    input  logic [OFF_W-1:0]             wr_word,
    input  logic [BE_W-1:0]              wr_be,
    input  logic [DATA_W-1:0]            wr_data
);
    localparam int unsigned DEPTH = SETS * WORDS;

    logic [NWAYS-1:0][DATA_W-1:0] ev_each;

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        logic [DATA_W-1:0] mem [DEPTH];

        // Byte-merged write into this way.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == 1'(w))) begin
                for (int b = 0; b < BE_W; b++) begin
                    if (wr_be[b]) mem[{wr_set, wr_word}][b*8 +: 8] <= wr_data[b*8 +: 8];
                end
            end
        end

        assign lk_data[w] = mem[{lk_set, lk_word}];
        assign ev_each[w] = mem[{ev_set, ev_word}];
    end

    assign ev_data = ev_each[ev_way];
endmodule

// File: rtl/vipt_way_select.sv
// Compares stored physical tags with the translated tag.
// Muxes out the hitting way's word and picks a victim for a miss.
// Victim rule: an invalid way (lowest first), else the recency bit.
module vipt_way_select
    import vipt_pkg::*;
#(
    parameter int unsigned TAG_W  = 18,
    parameter int unsigned DATA_W = 32
) (
    input  logic [NWAYS-1:0][TAG_W-1:0]  lk_tag,
    input  logic [NWAYS-1:0]             lk_valid,
    input  logic                         lk_lru,
    input  logic [NWAYS-1:0][DATA_W-1:0] lk_data,
    input  logic [TAG_W-1:0]             ptag,
    output logic                         tag_hit,
    output logic                         hit_way,
    output logic [DATA_W-1:0]            hit_data,
    output logic                         vict_way
);
    logic [NWAYS-1:0] match;

    for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
        assign match[w] = lk_valid[w] && (lk_tag[w] == ptag);
    end

    // Encode the matching way (at most one can match).
    always_comb begin
        hit_way = 1'b0;
        for (int w = NWAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = 1'(w);
        end
    end

    // Choose the victim: the first invalid way, otherwise the least recently used.
    always_comb begin
        vict_way = lk_lru;
        for (int w = NWAYS - 1; w >= 0; w--) begin
            if (!lk_valid[w]) vict_way = 1'(w);
        end
    end

    assign tag_hit  = |match;
    assign hit_data = lk_data[hit_way];
endmodule

// File: rtl/vipt_miss_ctrl.sv
// Miss sequencer: optional four-beat writeback of a dirty victim, then a
// four-beat fill.  Captures set, tags and way at miss start.
// Assumes the memory holds a beat until it acknowledges it.
module vipt_miss_ctrl
    import vipt_pkg::*;
#(
    parameter int unsigned SETS   = 256,
    parameter int unsigned WORDS  = 4,
    parameter int unsigned TAG_W  = 18,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned IDX_W = $clog2(SETS),
    localparam int unsigned OFF_W = $clog2(WORDS),
    localparam int unsigned BYT_W = $clog2(DATA_W / 8),
    localparam int unsigned PA_W  = TAG_W + IDX_W + OFF_W + BYT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] start_set,
    input  logic [TAG_W-1:0] start_ptag,
    input  logic             start_way,
    input  logic [TAG_W-1:0] vict_tag,
    input  logic             vict_dirty,
    input  logic             mem_ack,
    output logic             busy,
    output logic             mem_req,
    output logic             mem_we,
    output logic [PA_W-1:0]  mem_addr,
    output logic             fill_wr,
    output logic             fill_done,
    output logic [IDX_W-1:0] cur_set,
    output logic             cur_way,
    output logic [OFF_W-1:0] cur_word,
    output logic [TAG_W-1:0] cur_ptag
);
    localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(WORDS - 1);

    cs_t              st_q;
    logic [OFF_W-1:0] beat_q;
    logic [IDX_W-1:0] set_q;
    logic [TAG_W-1:0] ptag_q;
    logic [TAG_W-1:0] vtag_q;
    logic             way_q;

    // Sequence the writeback and fill beats and capture the miss context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= CS_IDLE;
            beat_q <= '0;
            set_q  <= '0;
            ptag_q <= '0;
            vtag_q <= '0;
            way_q  <= 1'b0;
        end else begin
            unique case (st_q)
                CS_IDLE: begin
                    if (start) begin
                        set_q  <= start_set;
                        ptag_q <= start_ptag;
                        vtag_q <= vict_tag;
                        way_q  <= start_way;
                        beat_q <= '0;
                        st_q   <= vict_dirty ? CS_WBACK : CS_FILL;
                    end
                end
                CS_WBACK: begin
                    if (mem_ack) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == LAST_BEAT) st_q <= CS_FILL;
                    end
                end
                CS_FILL: begin
                    if (mem_ack) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == LAST_BEAT) st_q <= CS_IDLE;
                    end
                end
                default: st_q <= CS_IDLE;
            endcase
        end
    end

    assign busy      = (st_q != CS_IDLE);
    assign mem_req   = busy;
    assign mem_we    = (st_q == CS_WBACK);
    assign mem_addr  = {(mem_we ? vtag_q : ptag_q), set_q, beat_q, {BYT_W{1'b0}}};
    assign fill_wr   = (st_q == CS_FILL) && mem_ack;
    assign fill_done = fill_wr && (beat_q == LAST_BEAT);
    assign cur_set   = set_q;
    assign cur_way   = way_q;
    assign cur_word  = beat_q;
    assign cur_ptag  = ptag_q;
endmodule

// File: rtl/vipt_dcache.sv
// Two-way write-back, write-allocate data cache.  It is indexed by
// untranslated page-offset bits and tagged with the translated physical tag.
// Assumes the requester holds request and translation stable until
// resp_valid; a miss refills, after which the held request hits.
module vipt_dcache
    import vipt_pkg::*;
#(
    parameter int unsigned SETS   = 256,
    parameter int unsigned WORDS  = 4,
    parameter int unsigned TAG_W  = 18,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned IDX_W  = $clog2(SETS),
    localparam int unsigned OFF_W  = $clog2(WORDS),
    localparam int unsigned VIDX_W = IDX_W + OFF_W,
    localparam int unsigned BE_W   = DATA_W / 8,
    localparam int unsigned PA_W   = TAG_W + VIDX_W + $clog2(BE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [VIDX_W-1:0] req_vidx,
    input  logic [BE_W-1:0]   req_be,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              xlat_hit,
    input  logic              xlat_fault,
    input  logic [TAG_W-1:0]  xlat_ptag,
    output logic              resp_valid,
    output logic              resp_fault,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic [IDX_W-1:0]             lk_set;
    logic [OFF_W-1:0]             lk_word;
    logic [NWAYS-1:0][TAG_W-1:0]  lk_tag;
    logic [NWAYS-1:0]             lk_valid;
    logic [NWAYS-1:0]             lk_dirty;
    logic                         lk_lru;
    logic [NWAYS-1:0][DATA_W-1:0] lk_data;
    logic                         tag_hit;
    logic                         hit_way;
    logic                         vict_way;
    logic                         busy;
    logic                         lookup;
    logic                         xlat_ok;
    logic                         hit_acc;
    logic                         miss_start;
    logic                         fill_wr;
    logic                         fill_done;
    logic [IDX_W-1:0]             cur_set;
    logic                         cur_way;
    logic [OFF_W-1:0]             cur_word;
    logic [TAG_W-1:0]             cur_ptag;
    logic                         wr_en;
    logic                         wr_way;
    logic [IDX_W-1:0]             wr_set;
    logic [OFF_W-1:0]             wr_word;
    logic [BE_W-1:0]              wr_be;
    logic [DATA_W-1:0]            wr_data;

    // Split the untranslated word address into set and word select.
    assign lk_set  = req_vidx[VIDX_W-1:OFF_W];
    assign lk_word = req_vidx[OFF_W-1:0];

    // Classify the presented access: abort, hit, miss or stall.
    assign lookup     = req_valid && !busy;
    assign xlat_ok    = xlat_hit && !xlat_fault;
    assign hit_acc    = lookup && xlat_ok && tag_hit;
    assign miss_start = lookup && xlat_ok && !tag_hit;
    assign resp_fault = lookup && xlat_fault;
    assign resp_valid = resp_fault || hit_acc;

    // Data write port: refill beats have priority over (mutually exclusive) write hits.
    assign wr_en   = fill_wr || (hit_acc && req_write);
    assign wr_way  = fill_wr ? cur_way  : hit_way;
    assign wr_set  = fill_wr ? cur_set  : lk_set;
    assign wr_word = fill_wr ? cur_word : lk_word;
    assign wr_be   = fill_wr ? {BE_W{1'b1}} : req_be;
    assign wr_data = fill_wr ? mem_rdata : req_wdata;

    vipt_tag_store #(
        .SETS (SETS),
        .TAG_W(TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_set   (lk_set),
        .lk_tag   (lk_tag),
        .lk_valid (lk_valid),
        .lk_dirty (lk_dirty),
        .lk_lru   (lk_lru),
        .touch_en (hit_acc),
        .touch_way(hit_way),
        .mark_en  (hit_acc && req_write),
        .mark_way (hit_way),
        .fill_en  (fill_done),
        .fill_set (cur_set),
        .fill_way (cur_way),
        .fill_tag (cur_ptag)
    );

    vipt_data_store #(
        .SETS  (SETS),
        .WORDS (WORDS),
        .DATA_W(DATA_W)
    ) u_data (
        .clk    (clk),
        .lk_set (lk_set),
        .lk_word(lk_word),
        .lk_data(lk_data),
        .ev_way (cur_way),
        .ev_set (cur_set),
        .ev_word(cur_word),
        .ev_data(mem_wdata),
        .wr_en  (wr_en),
        .wr_way (wr_way),
        .wr_set (wr_set),
        .wr_word(wr_word),
        .wr_be  (wr_be),
        .wr_data(wr_data)
    );

    vipt_way_select #(
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_sel (
        .lk_tag  (lk_tag),
        .lk_valid(lk_valid),
        .lk_lru  (lk_lru),
        .lk_data (lk_data),
        .ptag    (xlat_ptag),
        .tag_hit (tag_hit),
        .hit_way (hit_way),
        .hit_data(resp_rdata),
        .vict_way(vict_way)
    );

    vipt_miss_ctrl #(
        .SETS  (SETS),
        .WORDS (WORDS),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (miss_start),
        .start_set (lk_set),
        .start_ptag(xlat_ptag),
        .start_way (vict_way),
        .vict_tag  (lk_tag[vict_way]),
        .vict_dirty(lk_valid[vict_way] && lk_dirty[vict_way]),
        .mem_ack   (mem_ack),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .fill_wr   (fill_wr),
        .fill_done (fill_done),
        .cur_set   (cur_set),
        .cur_way   (cur_way),
        .cur_word  (cur_word),
        .cur_ptag  (cur_ptag)
    );
endmodule

// File: rtl/vipt_dcache_chk.sv
// Port-level protocol checker for vipt_dcache, attached by bind.
// Assumes OFF_W word-select bits sit just above the byte bits of mem_addr.
module vipt_dcache_chk #(
    parameter int unsigned OFF_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             xlat_hit,
    input logic             xlat_fault,
    input logic             resp_valid,
    input logic             resp_fault,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_ack,
    input logic [OFF_W-1:0] mem_beat
);
    // An abort completes at once and never coincides with memory traffic.
    p_fault_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault |-> (resp_valid && !mem_req));

    // A normal completion needs a usable translation.
    p_hit_needs_xlat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_fault) |-> (xlat_hit && !xlat_fault));

    // No translation and no fault: no response.
    p_stall_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !xlat_hit && !xlat_fault) |-> !resp_valid);

    // No response while a line transfer is running.
    p_busy_no_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !resp_valid);

    // An unacknowledged beat is held.
    p_beat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_beat) && $stable(mem_we)));

    // An acknowledged beat that is not the last is followed by the next word.
    p_beat_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && (mem_beat != '1)) |=>
        (mem_req && (mem_beat == OFF_W'($past(mem_beat) + 1'b1))));

    // Transfers start at the block-aligned word.
    p_start_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> (mem_beat == '0));

    // A finished writeback is followed by the fill reads.
    p_wb_then_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack && (mem_beat == '1)) |=> (mem_req && !mem_we));
endmodule

bind vipt_dcache vipt_dcache_chk #(.OFF_W(OFF_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .xlat_hit  (xlat_hit),
    .xlat_fault(xlat_fault),
    .resp_valid(resp_valid),
    .resp_fault(resp_fault),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_beat  (mem_addr[OFF_W+1:2])
);

// File: tb/test_vipt_dcache.sv
module test_vipt_dcache;
    localparam int CLK_PERIOD = 10;
    localparam int SETS = 256, WORDS = 4, TAG_W = 18, DATA_W = 32;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0;
    logic [9:0]  req_vidx = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        xlat_hit = 0, xlat_fault = 0;
    logic [17:0] xlat_ptag = '0;
    logic        resp_valid, resp_fault;
    logic [31:0] resp_rdata;
    logic        mem_req, mem_we;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 0;
    logic [31:0] mem_rdata = '0;

    vipt_dcache #(.SETS(SETS), .WORDS(WORDS), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_vipt_dcache (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_vidx(req_vidx), .req_be(req_be), .req_wdata(req_wdata),
        .xlat_hit(xlat_hit), .xlat_fault(xlat_fault), .xlat_ptag(xlat_ptag),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_rdata(resp_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Physical memory seen over the port, and the architectural expectation.
    logic [31:0] phys [64];
    logic [31:0] gold [64];
    int n_cmp = 0, n_bad = 0;
    int rd_beats, wr_beats, nlog;
    logic [29:0] log_addr [16];
    logic        log_we   [16];

    function automatic int midx(int ptag, int set, int word);
        return ((ptag & 3) << 4) | ((set & 3) << 2) | (word & 3);
    endfunction

    function automatic logic [29:0] pa_of(int ptag, int set, int word);
        return {18'(ptag), 8'(set), 2'(word), 2'b00};
    endfunction

    function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Memory responder: random acknowledge delay, transfer decided at the falling edge.
    always @(negedge clk) begin
        if (mem_req && ($urandom_range(0, 3) != 0)) begin
            mem_ack = 1'b1;
            mem_rdata = phys[{mem_addr[13:12], mem_addr[5:4], mem_addr[3:2]}];
            if (mem_we) begin
                phys[{mem_addr[13:12], mem_addr[5:4], mem_addr[3:2]}] = mem_wdata;
                wr_beats++;
            end else rd_beats++;
            if (nlog < 16) begin
                log_addr[nlog] = mem_addr;
                log_we[nlog] = mem_we;
                nlog++;
            end
        end else begin
            mem_ack = 1'b0;
            mem_rdata = $urandom;
        end
    end

    task automatic access(input bit wr, input int set, input int word, input int ptag,
                          input logic [3:0] be, input logic [31:0] wd, input bit flt,
                          input int stall, output logic [31:0] rd, output bit gotflt);
        rd_beats = 0; wr_beats = 0; nlog = 0;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_vidx = {8'(set), 2'(word)};
        req_be = be; req_wdata = wd; xlat_ptag = 18'(ptag);
        xlat_hit = 0; xlat_fault = 0;
        for (int i = 0; i < stall; i++) begin
            #1;
            check(!resp_valid && !mem_req, "R9 stall", {resp_valid, mem_req}, 0);
            @(negedge clk);
        end
        xlat_hit = !flt; xlat_fault = flt;
        forever begin
            #1;
            if (resp_valid) break;
            @(negedge clk);
        end
        rd = resp_rdata; gotflt = resp_fault;
        @(posedge clk);
        #1;
        req_valid = 0; xlat_hit = 0; xlat_fault = 0;
        if (wr && !flt) gold[midx(ptag, set, word)] = merge(gold[midx(ptag, set, word)], wd, be);
    endtask

    task automatic traffic(input string req, input int nwr, input int nrd);
        check(wr_beats == nwr && rd_beats == nrd, req, {wr_beats[31:0], rd_beats[31:0]},
              {nwr[31:0], nrd[31:0]});
    endtask

    // Beat order: nwr writebacks at wtag then four fills at rtag, ascending words.
    task automatic order(input string req, input int nwr, input int wtag, input int rtag, input int set);
        for (int i = 0; i < nwr + 4; i++) begin
            logic [29:0] ea;
            ea = (i < nwr) ? pa_of(wtag, set, i % 4) : pa_of(rtag, set, i % 4);
            check(log_addr[i] == ea && log_we[i] == (i < nwr), req, {log_we[i], log_addr[i]},
                  {(i < nwr), ea});
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL R3 watchdog expired actual=hung expected=done");
        summary();
    end

    initial begin
        logic [31:0] rd;
        bit fl;
        void'($urandom(32'd2718));
        for (int i = 0; i < 64; i++) begin
            phys[i] = $urandom;
            gold[i] = phys[i];
        end
        repeat (3) @(posedge clk);
        #1; rst_n = 1;
        #1;
        check(!resp_valid && !mem_req, "R1 reset outputs", {resp_valid, mem_req}, 0);

        // Cold miss, order and data.
        access(0, 0, 1, 0, 4'h0, 0, 0, 0, rd, fl);
        check(rd == gold[midx(0, 0, 1)], "R1 cold read data", rd, gold[midx(0, 0, 1)]);
        traffic("R1 cold miss refills", 0, 4);
        order("R10 fill order", 0, 0, 0, 0);
        access(0, 0, 3, 0, 4'h0, 0, 0, 0, rd, fl);
        check(rd == gold[midx(0, 0, 3)], "R3 hit data", rd, gold[midx(0, 0, 3)]);
        traffic("R3 hit no traffic", 0, 0);

        // Same index, other physical tag: alias must miss.
        access(0, 0, 0, 1, 4'h0, 0, 0, 0, rd, fl);
        check(rd == gold[midx(1, 0, 0)], "R2 alias data", rd, gold[midx(1, 0, 0)]);
        traffic("R2 alias misses", 0, 4);

        // Byte-merged write hit.
        access(1, 0, 2, 0, 4'b0101, 32'hA5A5_5A5A, 0, 0, rd, fl);
        traffic("R4 write hit no traffic", 0, 0);
        access(0, 0, 2, 0, 4'h0, 0, 0, 0, rd, fl);
        check(rd == gold[midx(0, 0, 2)], "R4 merged bytes", rd, gold[midx(0, 0, 2)]);

        // Recency: ptag0 recent, so ptag1 (clean) is evicted.
        access(0, 0, 0, 2, 4'h0, 0, 0, 0, rd, fl);
        traffic("R6 clean victim no writeback", 0, 4);
        access(0, 0, 0, 0, 4'h0, 0, 0, 0, rd, fl);
        traffic("R7 recent way kept", 0, 0);

        // Dirty eviction of ptag0, then of ptag2.
        access(1, 0, 3, 2, 4'hF, 32'h1234_5678, 0, 0, rd, fl);
        traffic("R4 write hit ptag2", 0, 0);
        access(0, 0, 1, 3, 4'h0, 0, 0, 0, rd, fl);
        traffic("R6 dirty victim writeback", 4, 4);
        order("R6 writeback before fill", 4, 0, 3, 0);
        check(phys[midx(0, 0, 2)] == gold[midx(0, 0, 2)], "R6 written back data",
              phys[midx(0, 0, 2)], gold[midx(0, 0, 2)]);
        access(0, 0, 2, 0, 4'h0, 0, 0, 0, rd, fl);
        traffic("R7 LRU dirty victim", 4, 4);
        check(rd == gold[midx(0, 0, 2)], "R6 reload after writeback", rd, gold[midx(0, 0, 2)]);

        // Write miss allocates.
        access(1, 1, 0, 1, 4'hF, 32'hCAFE_F00D, 0, 0, rd, fl);
        traffic("R5 write miss fetches line", 0, 4);
        access(0, 1, 1, 1, 4'h0, 0, 0, 0, rd, fl);
        check(rd == gold[midx(1, 1, 1)], "R5 neighbour word", rd, gold[midx(1, 1, 1)]);
        access(0, 1, 0, 1, 4'h0, 0, 0, 0, rd, fl);
        check(rd == 32'hCAFE_F00D, "R5 written word", rd, 32'hCAFE_F00D);

        // Faults abort without effect.
        access(1, 1, 0, 1, 4'hF, 32'hDEAD_BEEF, 1, 0, rd, fl);
        check(fl == 1'b1, "R8 fault reported", fl, 1);
        traffic("R8 fault no traffic", 0, 0);
        access(0, 1, 0, 1, 4'h0, 0, 0, 0, rd, fl);
        check(rd == 32'hCAFE_F00D && !fl, "R8 faulted write ignored", rd, 32'hCAFE_F00D);
        access(0, 1, 2, 3, 4'h0, 0, 1, 0, rd, fl);
        traffic("R8 fault on miss no traffic", 0, 0);

        // Translation stall.
        access(0, 1, 1, 1, 4'h0, 0, 0, 5, rd, fl);
        check(rd == gold[midx(1, 1, 1)], "R9 data after stall", rd, gold[midx(1, 1, 1)]);

        // Seeded random mix.
        for (int n = 0; n < 2500; n++) begin
            bit wr, flt;
            int set, word, ptag, stall;
            logic [3:0] be;
            logic [31:0] wd;
            wr = 1'($urandom_range(0, 1));
            flt = ($urandom_range(0, 15) == 0);
            set = $urandom_range(0, 3);
            word = $urandom_range(0, 3);
            ptag = $urandom_range(0, 3);
            stall = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 2) : 0;
            be = 4'($urandom);
            wd = $urandom;
            access(wr, set, word, ptag, be, wd, flt, stall, rd, fl);
            if (flt) check(fl == 1'b1 && wr_beats == 0 && rd_beats == 0, "R8 random fault", fl, 1);
            else if (!wr) check(rd == gold[midx(ptag, set, word)] && !fl, "R3 random read",
                                rd, gold[midx(ptag, set, word)]);
            else check(!fl, "R4 random write completes", fl, 0);
        end
        summary();
    end
endmodule